// File: doc/BRIEF.md
# Protected Battery-Domain Register File

This block is a small register file that lives in a battery-backed supply domain. It holds ten 16-bit words of user data and one control word. The control word carries a write-once selector for the clock source of a real-time counter, and a bit that clears the domain from software. A simple register bus reads and writes the file. Reads are combinational and never gated. Writes take effect only when the interface clock enable and the domain-access enable from the power controller are both high.

The system reset and the power reset of the main logic reach this block, but they do not clear it. This lets the stored words survive a chip reset and a wake from standby. Only two things clear the domain. The first is its own power-on reset, raised when both the main and battery supplies had been lost. The second is the software reset bit, which holds the domain cleared for as long as it stays set.

Top module: `bkdom_regfile`

## Requirements
- R1: Addresses 0 to 9 select ten independent 16-bit data words. An accepted write to one of them is visible on `rd_data` from the next clock edge, and no other word changes.
- R2: Asserting `sys_rst_n` or `pwr_rst_n` low has no effect on any stored word, on the selector, or on the reset bit.
- R3: While `dom_por_n` is low, and after it is released, every data word, the selector and the reset bit read zero.
- R4: A write is accepted only if `clk_en` and `acc_en` are both 1 on its clock edge. Otherwise the addressed register is left unchanged.
- R5: A write presented while either enable is low makes `wr_err` high for exactly the following clock cycle. An accepted write, or an idle cycle, leaves `wr_err` low in the following cycle.
- R6: `rd_data` always shows the addressed register, whatever the values of `clk_en` and `acc_en`.
- R7: Address 10 is the control word. Bits [1:0] are the clock-source selector, also driven on `rtc_src`, with the encoding 00 none, 01 low-speed external, 10 low-speed internal and 11 high-speed external divided by 128. Bit 15 is the domain reset bit. All other bits read 0.
- R8: The selector accepts a new value only while it reads 00. Once it is nonzero, later control writes leave it unchanged until the domain is cleared.
- R9: An accepted control write with bit 15 set clears all data words and the selector at that edge. While bit 15 stays set, the domain stays cleared and data writes are dropped without an error. An accepted control write with bit 15 clear releases the hold.
- R10: Addresses 11 to 15 read as zero. A write to them changes nothing and raises no error when both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| dom_por_n | input | 1 | Domain power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset of the main logic, active low, has no effect on the domain |
| pwr_rst_n | input | 1 | Power reset of the main logic, active low, has no effect on the domain |
| clk_en | input | 1 | Interface clock enable |
| acc_en | input | 1 | Domain-access enable from the power controller |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `bus_addr` |
| wr_err | output | 1 | One-cycle pulse after a blocked write |
| rtc_src | output | 2 | Real-time counter clock-source selector |

## Verification
The assertions assume that the bus inputs are stable around the rising edge, and that `dom_por_n` is the only asynchronous input. Their antecedents are written so that they do not depend on what the main-domain resets are doing. The bench changes every input on the falling edge, and it pulses `dom_por_n` only there. It randomises the enables so that about half of all writes are blocked. Writes that set the domain reset bit are kept rare, so that the data words and the selector stay populated long enough to catch writes that leak through.

// File: rtl/bkdom_pkg.sv
`timescale 1ns/1ps
package bkdom_pkg;
    localparam int unsigned NUM_WORDS = 10;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned RST_BIT   = 15;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_LSX   = 2'b01,
        SRC_LSI   = 2'b10,
        SRC_HSD   = 2'b11
    } rtc_src_e;
endpackage

// File: rtl/bkdom_gate.sv
`timescale 1ns/1ps
module bkdom_gate (
    input  logic clk,
    input  logic por_n,
    input  logic bus_wr,
    input  logic clk_en,
    input  logic acc_en,
    output logic wr_ok,
    output logic wr_err
);
    typedef struct packed {
        logic err;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic open_w;

    always_comb begin
        st_d     = st_q;
        open_w   = clk_en & acc_en;
        wr_ok    = bus_wr & open_w;
        st_d.err = bus_wr & ~open_w;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_err = st_q.err;

    a_r5_ok_no_err: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && clk_en && acc_en) |=> !wr_err);
    a_r5_idle_no_err: assert property (@(posedge clk) disable iff (!por_n)
        !bus_wr |=> !wr_err);
endmodule

// File: rtl/bkdom_store.sv
`timescale 1ns/1ps
module bkdom_store #(
    parameter int unsigned N  = bkdom_pkg::NUM_WORDS,
    parameter int unsigned DW = bkdom_pkg::WORD_W,
    parameter int unsigned AW = bkdom_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_ok,
    input  logic              wipe,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [N*DW-1:0]   words
);
    typedef struct packed {
        logic [N-1:0][DW-1:0] w;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wipe) begin
            st_d.w = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_ok && addr == AW'(i)) st_d.w[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.w;

    a_r4_no_write_stable: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_ok && !wipe) |=> $stable(st_q.w));
    a_r9_wipe_clears: assert property (@(posedge clk) disable iff (!por_n)
        wipe |=> (st_q.w == '0));
endmodule

// File: rtl/bkdom_ctrl.sv
`timescale 1ns/1ps
module bkdom_ctrl #(
    parameter int unsigned DW        = bkdom_pkg::WORD_W,
    parameter int unsigned AW        = bkdom_pkg::ADDR_W,
    parameter int unsigned SW        = bkdom_pkg::SEL_W,
    parameter int unsigned CTRL_ADDR = bkdom_pkg::NUM_WORDS,
    parameter int unsigned RB        = bkdom_pkg::RST_BIT
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wr_ok,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [SW-1:0] sel,
    output logic          hold,
    output logic          wipe
);
    typedef struct packed {
        logic [SW-1:0] sel;
        logic          hold;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = wr_ok && (addr == AW'(CTRL_ADDR));
        wipe = st_q.hold || (hit && wdata[RB]);
        if (hit) begin
            st_d.hold = wdata[RB];
            if (wdata[RB])                    st_d.sel = '0;
            else if (st_q.sel == '0)          st_d.sel = wdata[SW-1:0];
        end else if (st_q.hold) begin
            st_d.sel = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel  = st_q.sel;
    assign hold = st_q.hold;

    a_r8_sel_locked: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.sel != '0 && !wipe) |=> (st_q.sel == $past(st_q.sel)));
    a_r9_hold_sel_zero: assert property (@(posedge clk) disable iff (!por_n)
        st_q.hold |-> (st_q.sel == '0));
endmodule

// File: rtl/bkdom_regfile.sv
`timescale 1ns/1ps
module bkdom_regfile #(
    parameter int unsigned N  = bkdom_pkg::NUM_WORDS,
    parameter int unsigned DW = bkdom_pkg::WORD_W,
    parameter int unsigned AW = bkdom_pkg::ADDR_W,
    parameter int unsigned SW = bkdom_pkg::SEL_W,
    parameter int unsigned RB = bkdom_pkg::RST_BIT
) (
    input  logic          clk,
    input  logic          dom_por_n,
    input  logic          sys_rst_n,
    input  logic          pwr_rst_n,
    input  logic          clk_en,
    input  logic          acc_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rd_data,
    output logic          wr_err,
    output logic [SW-1:0] rtc_src
);
    localparam int unsigned CTRL_ADDR = N;

    logic                 wr_ok, wipe, hold;
    logic [N*DW-1:0]      words;
    logic [SW-1:0]        sel;

    bkdom_gate u_gate (
        .clk(clk), .por_n(dom_por_n), .bus_wr(bus_wr),
        .clk_en(clk_en), .acc_en(acc_en), .wr_ok(wr_ok), .wr_err(wr_err)
    );

    bkdom_store #(.N(N), .DW(DW), .AW(AW)) u_store (
        .clk(clk), .por_n(dom_por_n), .wr_ok(wr_ok), .wipe(wipe),
        .addr(bus_addr), .wdata(bus_wdata), .words(words)
    );

    bkdom_ctrl #(.DW(DW), .AW(AW), .SW(SW), .CTRL_ADDR(CTRL_ADDR), .RB(RB)) u_ctrl (
        .clk(clk), .por_n(dom_por_n), .wr_ok(wr_ok), .addr(bus_addr),
        .wdata(bus_wdata), .sel(sel), .hold(hold), .wipe(wipe)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (bus_addr == AW'(i)) rd_data = words[i*DW +: DW];
        end
        if (bus_addr == AW'(CTRL_ADDR)) begin
            rd_data[SW-1:0] = sel;
            rd_data[RB]     = hold;
        end
    end

    assign rtc_src = sel;

    a_r2_main_resets_ignored: assert property (@(posedge clk) disable iff (!dom_por_n)
        ((!sys_rst_n || !pwr_rst_n) && !wr_ok && !hold) |=> ($stable(words) && $stable(sel)));
    a_r3_por_clear: assert property (@(posedge clk)
        !dom_por_n |-> (words == '0 && sel == '0 && !hold));
endmodule

// File: tb/bkdom_regfile_test.sv
`timescale 1ns/1ps
module bkdom_regfile_test;
    logic        clk = 1'b0;
    logic        dom_por_n = 1'b0, sys_rst_n = 1'b1, pwr_rst_n = 1'b1;
    logic        clk_en = 1'b0, acc_en = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic        wr_err;
    logic [1:0]  rtc_src;

    always #2.5 clk = ~clk;

    bkdom_regfile uut (.*);

    int          n_run = 0, n_fail = 0;
    logic [15:0] m_reg [10];
    logic [1:0]  m_sel;
    logic        m_hold;
    bit          done = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(int a);
        if (a < 10)  return m_hold ? 16'h0 : m_reg[a];
        if (a == 10) return {m_hold, 13'h0, m_sel};
        return 16'h0;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 10; i++) m_reg[i] = '0;
        m_sel = '0; m_hold = 1'b0;
    endtask

    task automatic model_wr(int a, logic [15:0] d, bit open);
        if (!open) return;
        if (a < 10) begin
            if (!m_hold) m_reg[a] = d;
        end else if (a == 10) begin
            if (d[15]) begin
                for (int i = 0; i < 10; i++) m_reg[i] = '0;
                m_sel = '0; m_hold = 1'b1;
            end else begin
                m_hold = 1'b0;
                if (m_sel == 2'b00) m_sel = d[1:0];
            end
        end
    endtask

    // drive at negedge, edge happens, check at the following negedge
    task automatic do_wr(string req, int a, logic [15:0] d, bit ce, bit ae);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; clk_en = ce; acc_en = ae; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(a, d, ce & ae);
        chk({req, " R5 err"}, 32'(wr_err), 32'(!(ce & ae)));
    endtask

    task automatic chk_all(string req);
        for (int i = 0; i < 16; i++) begin
            bus_addr = 4'(i);
            #0.2;
            chk(req, 32'(rd_data), 32'(exp_read(i)));
        end
        chk({req, " R7 rtc_src"}, 32'(rtc_src), 32'(m_sel));
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(negedge clk);
        chk_all("R3 during por");
        dom_por_n = 1'b1;
        @(negedge clk);
        chk_all("R3 after por");

        // R4: each enable combination
        do_wr("R4 both off", 3, 16'hAAAA, 0, 0);
        do_wr("R4 only ce", 3, 16'hBBBB, 1, 0);
        do_wr("R4 only ae", 3, 16'hCCCC, 0, 1);
        chk_all("R4 blocked unchanged");
        do_wr("R1 word3", 3, 16'h1234, 1, 1);
        do_wr("R1 word0", 0, 16'hFFFF, 1, 1);
        do_wr("R1 word9", 9, 16'h00A5, 1, 1);
        chk_all("R1 readback");
        @(negedge clk);
        chk("R5 idle no err", 32'(wr_err), 32'h0);

        // R6: reads with enables off
        clk_en = 0; acc_en = 0;
        chk_all("R6 read gated off");

        // R10 out-of-range
        do_wr("R10 addr12", 12, 16'hDEAD, 1, 1);
        do_wr("R10 addr15", 15, 16'hBEEF, 1, 1);
        chk_all("R10 unchanged");

        // R7/R8 selector
        do_wr("R7 set sel", 10, 16'h0002, 1, 1);
        chk("R7 rtc_src LSI", 32'(rtc_src), 32'h2);
        do_wr("R8 change sel", 10, 16'h0003, 1, 1);
        chk("R8 sel locked", 32'(rtc_src), 32'h2);
        chk_all("R8 state");

        // R2 main resets
        @(negedge clk); sys_rst_n = 0;
        repeat (3) @(negedge clk); pwr_rst_n = 0;
        repeat (3) @(negedge clk); sys_rst_n = 1; pwr_rst_n = 1;
        chk_all("R2 main resets ignored");

        // R9 domain reset hold
        do_wr("R9 set rst", 10, 16'h8000, 1, 1);
        chk_all("R9 cleared");
        do_wr("R9 data during hold", 4, 16'h5555, 1, 1);
        chk_all("R9 held clear");
        do_wr("R9 release and set sel", 10, 16'h0001, 1, 1);
        chk_all("R9 released");
        do_wr("R9 write after release", 4, 16'h5555, 1, 1);
        chk_all("R9 data after release");

        // random phase
        for (int k = 0; k < 600; k++) begin
            int a; logic [15:0] d; bit ce, ae;
            a  = int'($urandom_range(0, 12));
            d  = 16'($urandom);
            if (a == 10 && $urandom_range(0, 7) != 0) d[15] = 1'b0;
            ce = ($urandom_range(0, 3) != 0);
            ae = ($urandom_range(0, 3) != 0);
            do_wr("R4 random", a, d, ce, ae);
            if (k % 25 == 0) begin
                sys_rst_n = 1'($urandom_range(0, 1));
                pwr_rst_n = 1'($urandom_range(0, 1));
                chk_all("R1 random readback");
            end
        end
        sys_rst_n = 1; pwr_rst_n = 1;
        chk_all("R1 random final");

        // R3 power-on mid run
        @(negedge clk); dom_por_n = 0;
        #0.2;
        model_clear();
        chk_all("R3 por mid run");
        @(negedge clk); dom_por_n = 1;
        @(negedge clk);
        chk_all("R3 after por release");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule